// File: doc/BRIEF.md
# DRAM Parallel Test Mode Controller

This block is the device-side control for a two-bit parallel test function in a dynamic memory. It watches the row strobe, column strobe and write enable, which arrive already synchronized to the internal clock, and sorts each row cycle into one of four kinds. The first kind is a combined write-and-column-before-row cycle, which arms test mode. The second is a column-before-row refresh with write enable high. The third is a row-only refresh, in which the column strobe never falls. The fourth is an ordinary access.

The device may only enter test mode after power-up initialization. Initialization is a run of row-only or column-before-row refresh cycles. In test mode, an ordinary read does not return a cell value. It returns one pass/fail level: high when the two array bits agree and low when they differ. That read also takes longer before its output is valid. Outside test mode, the column address bit picks one of the two array bits and the output carries it unchanged. Test mode ends only on a row-only refresh or on a column-before-row refresh with write enable high.

Top module: `dram_ptm_ctrl`

## Requirements
- R1: While rst_n is low and after its release, test_mode and dout_valid are 0.
- R2: A combined entry cycle (cas_n and we_n both 0 on the clock edge where ras_n is first sampled 0) has no effect until INIT_CYCLES (default 8) refresh cycles have completed, counting both row-only and column-before-row cycles.
- R3: After initialization, a combined entry cycle sets test_mode on that same clock edge.
- R4: While test_mode is 1, an ordinary read cycle, an ordinary write cycle or a further combined entry cycle leaves test_mode at 1.
- R5: A column-before-row cycle (cas_n 0 and we_n 1 on the edge where ras_n is first sampled 0) clears test_mode.
- R6: A row-only cycle clears test_mode on the edge where ras_n is first sampled 1 again. A row-only cycle is one in which ras_n is low, cas_n is high when ras_n falls, and cas_n does not fall before ras_n rises.
- R7: In a test-mode read, dout is 1 when arr_bits[0] equals arr_bits[1] and 0 when they differ.
- R8: In a read outside test mode, dout equals arr_bits[col_sel].
- R9: In a read (cas_n falling while ras_n is low, with we_n 1), dout_valid rises BASE_LAT clock edges after the edge where cas_n is first sampled 0. In test mode it rises BASE_LAT + extra_dly edges after that edge.
- R10: dout_valid falls on the first edge where cas_n or ras_n is sampled 1. A write (we_n 0 when cas_n falls) never raises dout_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Synchronized row strobe, active low |
| cas_n | input | 1 | Synchronized column strobe, active low |
| we_n | input | 1 | Synchronized write enable, active low |
| arr_bits | input | 2 | The two bits read from the array |
| col_sel | input | 1 | Column address bit that selects between the two bits in normal reads |
| extra_dly | input | DLY_W | Extra clock ticks of read latency in test mode |
| test_mode | output | 1 | Test mode flag |
| dout | output | 1 | Read data, or the compare result in test mode |
| dout_valid | output | 1 | dout holds valid read data |

## Verification
Two functions can meet in one row cycle: the mode tracking and the compare read. A read issued in test mode must return the compare result. It must also leave the flag set, and it must use the longer latency that was chosen when the column strobe fell. The bench provokes this with a random mix of refresh, entry, read and write cycles. Each read draws a fresh extra delay and fresh array bits. For every read, a bench model that follows the cycle sequence predicts the edge on which the output becomes valid, the value of dout and the state of the flag after the cycle.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
  typedef struct packed {
    logic entry;    // combined write/column-before-row
    logic cbr;      // column-before-row, write high
    logic ras_only; // row cycle ended with no column strobe
    logic rd_start; // column strobe fell in a read
  } ptm_ev_t;
endpackage

// File: rtl/ptm_strobe_decode.sv
module ptm_strobe_decode
  import ptm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ras_n,
  input  logic    cas_n,
  input  logic    we_n,
  output ptm_ev_t ev
);
  logic ras_q, cas_q, cbr_cyc, cas_seen;
  logic cbr_cyc_nx, cas_seen_nx;
  logic ras_fall, ras_rise, cas_fall;

  always_comb begin
    ras_fall    = ras_q & ~ras_n;
    ras_rise    = ~ras_q & ras_n;
    cas_fall    = ~ras_q & ~ras_n & cas_q & ~cas_n & ~cbr_cyc;
    ev.entry    = ras_fall & ~cas_n & ~we_n;
    ev.cbr      = ras_fall & ~cas_n & we_n;
    ev.ras_only = ras_rise & ~cbr_cyc & ~cas_seen;
    ev.rd_start = cas_fall & we_n;
    cbr_cyc_nx  = cbr_cyc;
    cas_seen_nx = cas_seen;
    if (ras_fall) begin
      cbr_cyc_nx  = ~cas_n;
      cas_seen_nx = 1'b0;
    end else if (ras_rise) begin
      cbr_cyc_nx  = 1'b0;
      cas_seen_nx = 1'b0;
    end else if (cas_fall) begin
      cas_seen_nx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q    <= 1'b1;
      cas_q    <= 1'b1;
      cbr_cyc  <= 1'b0;
      cas_seen <= 1'b0;
    end else begin
      ras_q    <= ras_n;
      cas_q    <= cas_n;
      cbr_cyc  <= cbr_cyc_nx;
      cas_seen <= cas_seen_nx;
    end
  end

  a_r2_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev.entry, ev.cbr, ev.ras_only, ev.rd_start}));
endmodule

// File: rtl/ptm_mode_fsm.sv
module ptm_mode_fsm
  import ptm_pkg::*;
#(
  parameter int INIT_CYCLES = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  ptm_ev_t ev,
  output logic    test_mode
);
  localparam int CNT_W = $clog2(INIT_CYCLES + 1);

  logic [CNT_W-1:0] init_cnt, init_cnt_nx;
  logic             init_done, tm_nx, cnt_en;

  always_comb begin
    init_done   = (init_cnt == CNT_W'(INIT_CYCLES));
    cnt_en      = ~init_done & (ev.cbr | ev.ras_only);
    init_cnt_nx = cnt_en ? init_cnt + 1'b1 : init_cnt;
    tm_nx       = test_mode;
    if (ev.entry && init_done)           tm_nx = 1'b1;
    else if (ev.cbr || ev.ras_only)      tm_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_cnt  <= '0;
      test_mode <= 1'b0;
    end else begin
      init_cnt  <= init_cnt_nx;
      test_mode <= tm_nx;
    end
  end

  a_r2_no_entry_early: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && !test_mode) |=> !test_mode);
  a_r3_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.entry && init_done) |=> test_mode);
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !ev.cbr && !ev.ras_only) |=> test_mode);
  a_r5_r6_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.cbr || ev.ras_only) |=> !test_mode);
endmodule

// File: rtl/ptm_read_path.sv
module ptm_read_path
  import ptm_pkg::*;
#(
  parameter int BASE_LAT = 2,
  parameter int DLY_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ptm_ev_t          ev,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             test_mode,
  input  logic [1:0]       arr_bits,
  input  logic             col_sel,
  input  logic [DLY_W-1:0] extra_dly,
  output logic             dout,
  output logic             dout_valid
);
  localparam int LAT_W = $clog2(BASE_LAT + (1 << DLY_W)) + 1;

  logic [LAT_W-1:0] cnt, cnt_nx, lat;
  logic pend, pend_nx, rd_tm, rd_tm_nx, val_nx, dout_nx, dout_en, end_cyc;

  always_comb begin
    end_cyc  = ras_n | cas_n;
    lat      = LAT_W'(BASE_LAT) + (test_mode ? LAT_W'(extra_dly) : '0);
    pend_nx  = pend;
    cnt_nx   = cnt;
    rd_tm_nx = rd_tm;
    val_nx   = dout_valid;
    dout_en  = 1'b0;
    dout_nx  = rd_tm ? ~(arr_bits[0] ^ arr_bits[1]) : arr_bits[col_sel];
    if (end_cyc) begin
      pend_nx = 1'b0;
      val_nx  = 1'b0;
    end else if (ev.rd_start) begin
      pend_nx  = 1'b1;
      cnt_nx   = lat - 1'b1;
      rd_tm_nx = test_mode;
    end else if (pend) begin
      if (cnt == '0) begin
        val_nx  = 1'b1;
        dout_en = 1'b1;
        pend_nx = 1'b0;
      end else begin
        cnt_nx = cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      cnt        <= '0;
      rd_tm      <= 1'b0;
      dout_valid <= 1'b0;
      dout       <= 1'b0;
    end else begin
      pend       <= pend_nx;
      cnt        <= cnt_nx;
      rd_tm      <= rd_tm_nx;
      dout_valid <= val_nx;
      if (dout_en) dout <= dout_nx;
    end
  end

  a_r10_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n || cas_n) |=> !dout_valid);
  a_r9_not_early: assert property (@(posedge clk) disable iff (!rst_n)
    ev.rd_start |=> !dout_valid);
  a_r7_compare: assert property (@(posedge clk) disable iff (!rst_n)
    (!dout_valid && !end_cyc && test_mode && pend && cnt == '0) |=>
      (dout == ($past(arr_bits[0]) == $past(arr_bits[1]))));
endmodule

// File: rtl/dram_ptm_ctrl.sv
module dram_ptm_ctrl
  import ptm_pkg::*;
#(
  parameter int INIT_CYCLES = 8,
  parameter int BASE_LAT    = 2,
  parameter int DLY_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [1:0]       arr_bits,
  input  logic             col_sel,
  input  logic [DLY_W-1:0] extra_dly,
  output logic             test_mode,
  output logic             dout,
  output logic             dout_valid
);
  ptm_ev_t ev;

  ptm_strobe_decode u_dec (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ev(ev)
  );

  ptm_mode_fsm #(.INIT_CYCLES(INIT_CYCLES)) u_mode (
    .clk(clk), .rst_n(rst_n), .ev(ev), .test_mode(test_mode)
  );

  ptm_read_path #(.BASE_LAT(BASE_LAT), .DLY_W(DLY_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .ev(ev), .ras_n(ras_n), .cas_n(cas_n),
    .test_mode(test_mode), .arr_bits(arr_bits), .col_sel(col_sel),
    .extra_dly(extra_dly), .dout(dout), .dout_valid(dout_valid)
  );

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!test_mode && !dout_valid));
endmodule

// File: tb/tb_dram_ptm_ctrl.sv
module tb_dram_ptm_ctrl;
  localparam int INIT_CYCLES = 8;
  localparam int BASE_LAT    = 2;
  localparam int DLY_W       = 3;

  logic clk = 1'b0;
  logic rst_n, ras_n, cas_n, we_n, col_sel;
  logic [1:0] arr_bits;
  logic [DLY_W-1:0] extra_dly;
  logic test_mode, dout, dout_valid;

  int n_chk = 0, n_fail = 0;
  int init_cnt = 0;
  logic exp_tm = 1'b0;
  bit done = 0;

  always #5 clk = ~clk;

  dram_ptm_ctrl #(.INIT_CYCLES(INIT_CYCLES), .BASE_LAT(BASE_LAT), .DLY_W(DLY_W)) dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .arr_bits(arr_bits), .col_sel(col_sel), .extra_dly(extra_dly),
    .test_mode(test_mode), .dout(dout), .dout_valid(dout_valid)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_data(input logic tm, input logic [1:0] b, input logic s);
    return tm ? (b[0] == b[1]) : b[s];
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_ras_only();
    @(negedge clk); ras_n = 1'b0;
    idle(3);
    ras_n = 1'b1;
    idle(2);
    if (init_cnt < INIT_CYCLES) init_cnt++;
    exp_tm = 1'b0;
    chk("R6 ras-only exit", test_mode, exp_tm);
  endtask

  task automatic do_cbr(input logic we);
    @(negedge clk); cas_n = 1'b0; we_n = we;
    @(negedge clk); ras_n = 1'b0;
    idle(3);
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    idle(2);
    if (we) begin
      if (init_cnt < INIT_CYCLES) init_cnt++;
      exp_tm = 1'b0;
      chk("R5 cbr exit", test_mode, exp_tm);
    end else begin
      if (init_cnt >= INIT_CYCLES) exp_tm = 1'b1;
      chk(init_cnt >= INIT_CYCLES ? "R3/R4 entry" : "R2 early entry ignored",
          test_mode, exp_tm);
    end
  endtask

  task automatic do_read(input logic [1:0] b, input logic s, input logic [DLY_W-1:0] d);
    int lat;
    logic ed;
    extra_dly = d;
    @(negedge clk); ras_n = 1'b0;
    @(negedge clk); arr_bits = b; col_sel = s; we_n = 1'b1; cas_n = 1'b0;
    lat = BASE_LAT + (exp_tm ? int'(d) : 0);
    ed  = exp_data(exp_tm, b, s);
    idle(lat);
    chk("R9 not valid before latency", dout_valid, 1'b0);
    @(negedge clk);
    chk("R9 valid at latency", dout_valid, 1'b1);
    chk(exp_tm ? "R7 compare" : "R8 pass-through", dout, ed);
    idle(2);
    chk("R10 valid held", dout_valid, 1'b1);
    cas_n = 1'b1;
    @(negedge clk);
    chk("R10 valid drops", dout_valid, 1'b0);
    ras_n = 1'b1;
    idle(2);
    chk("R4 read keeps mode", test_mode, exp_tm);
  endtask

  task automatic do_write();
    @(negedge clk); ras_n = 1'b0;
    @(negedge clk); we_n = 1'b0; cas_n = 1'b0;
    idle(BASE_LAT + (1 << DLY_W) + 1);
    chk("R10 write no valid", dout_valid, 1'b0);
    cas_n = 1'b1; we_n = 1'b1;
    @(negedge clk); ras_n = 1'b1;
    idle(2);
    chk("R4 write keeps mode", test_mode, exp_tm);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    arr_bits = 2'b00; col_sel = 1'b0; extra_dly = '0;
    idle(3);
    chk("R1 reset mode", test_mode, 1'b0);
    chk("R1 reset valid", dout_valid, 1'b0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 after release", test_mode, 1'b0);

    // R2: entry before init, then mixed init cycles
    do_cbr(1'b0);
    do_read(2'b10, 1'b1, 3'd5);
    for (int i = 0; i < INIT_CYCLES - 1; i++)
      if (i % 2 == 0) do_ras_only(); else do_cbr(1'b1);
    do_cbr(1'b0);            // still one short: ignored
    do_ras_only();           // init complete
    do_cbr(1'b0);            // R3 entry
    chk("R3 entered", test_mode, 1'b1);
    do_read(2'b11, 1'b0, 3'd0);  // R7 equal
    do_read(2'b01, 1'b0, 3'd7);  // R7 differ, max delay
    do_write();
    do_cbr(1'b0);            // R4 repeated entry
    do_cbr(1'b1);            // R5 exit
    do_read(2'b01, 1'b0, 3'd4);  // R8 normal
    do_cbr(1'b0);
    do_ras_only();           // R6 exit
    do_read(2'b10, 1'b1, 3'd6);

    for (int k = 0; k < 300; k++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: do_ras_only();
        1: do_cbr(1'b1);
        2: do_cbr(1'b0);
        3: do_write();
        default: do_read(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                         DLY_W'($urandom_range(0, (1 << DLY_W) - 1)));
      endcase
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule